// File: doc/BRIEF.md
# Receive Slip Buffer Phase Monitor

This block is a two-frame elastic store for a 2.048 Mbit/s receive path. Each frame has 32 time slots of 8 bits. Line bits arrive on the recovered line clock together with a line frame marker. They are read out bit-serially on a local system clock that has its own frame pulse. The two clocks are nominally equal but may drift apart. When the read side falls too far behind, or comes too close, the block performs a controlled frame slip at a read frame boundary. The read frame pointer then jumps one whole frame back (the frame is repeated) or one whole frame forward (a frame is dropped).

The write position crosses into the read domain as a Gray-coded bit address through a chain of synchroniser flops. Three status outputs describe the buffer:
- a slip indication that inverts on every slip;
- a direction flag recording the kind of the last slip;
- a phase word giving the distance from the read frame boundary to the write position. It is split into a time-slot count and a bit count, with a top bit that shows whether the delay is below one frame.

Top module: `slip_buffer_monitor`

## Requirements
- R1: While `rrst` is high, `sys_bit`, `slip_toggle`, `slip_repeat` and `phase_word` are driven to 0 on each `rclk` edge.
- R2: When `line_fp` is asserted with the first bit of every line frame, each bit read out appears on `sys_bit` one `rclk` cycle after its read address is taken. Outside slips, the bits appear in the order they were written.
- R3: At a `sys_fp` edge, let gap be the synchronised write address minus the candidate read frame start, modulo 512. If gap is below 16 bits (2 slots), the read pointer moves back one frame (256 bits) and the frame is repeated.
- R4: At a `sys_fp` edge with gap above 496 bits, the read pointer moves forward one frame and a frame is dropped.
- R5: `slip_toggle` inverts once for each slip and changes at no other time, including every edge without `sys_fp`.
- R6: `slip_repeat` becomes 1 on a repeat slip and 0 on a drop slip. It holds its value at every other edge.
- R7: The phase word is the post-slip gap. `phase_word[7:3]` holds the time-slot count (gap bits 7..3) and `phase_word[2:0]` holds the bit count (gap bits 2..0).
- R8: `phase_word[8]` is 1 when the post-slip gap is below 256 bits (less than one frame of delay) and 0 otherwise.
- R9: `phase_word` is refreshed only on the 1st, 3rd, 5th, ... `sys_fp` after reset, which is once every two frames. It holds between refreshes.
- R10: The write address seen by the read side is exactly the line write count as it stood two `rclk` edges earlier (two synchroniser stages).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Recovered line clock |
| wrst | input | 1 | Synchronous active-high reset, line domain |
| line_fp | input | 1 | High with the first bit of a line frame |
| line_bit | input | 1 | Line data bit |
| rclk | input | 1 | System clock |
| rrst | input | 1 | Synchronous active-high reset, system domain |
| sys_fp | input | 1 | High with the first bit of a system frame |
| sys_bit | output | 1 | System data bit, registered |
| slip_toggle | output | 1 | Inverts on every controlled slip |
| slip_repeat | output | 1 | 1 = last slip repeated a frame, 0 = dropped one |
| phase_word | output | 9 | {delay-below-frame, slot count[4:0], bit count[2:0]} |

## Verification
The bench drives the line clock first about 2.5 % faster and then about 2.5 % slower than the system clock. Both drop slips and repeat slips therefore occur, along with the repeat slip forced at the first frame after reset.

A reference model works from absolute bit indices and a two-edge delayed view of the write count. On every cycle it predicts the read data, the toggle, the direction and the phase word. Each kind of design error shows up as follows:
- A wrong guard comparison, or a jump of the wrong sign, leaves the read pointer on overwritten or unwritten data, and the data check fails.
- A direction flag that is not latched, or a phase word refreshed every frame or at the wrong parity, diverges from the model between frame pulses.
- An extra synchroniser stage shifts the gap by a bit, which shows up in the phase word.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

  typedef enum logic [1:0] {
    SLIP_NONE   = 2'd0,
    SLIP_REPEAT = 2'd1,
    SLIP_DROP   = 2'd2
  } slip_e;

  // binary to reflected Gray code, widths up to 16 bits
  function automatic logic [15:0] to_gray(input logic [15:0] b);
    return b ^ (b >> 1);
  endfunction

  // reflected Gray code back to binary
  function automatic logic [15:0] from_gray(input logic [15:0] g);
    logic [15:0] b;
    b[15] = g[15];
    for (int i = 14; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/sbm_mem.sv
module sbm_mem #(
  parameter int AW = 9
) (
  input  logic          wclk,
  input  logic [AW-1:0] waddr,
  input  logic          wbit,
  input  logic          rclk,
  input  logic          rrst,
  input  logic [AW-1:0] raddr,
  output logic          rbit
);
  localparam int DEPTH = 2 ** AW;

  logic store [DEPTH];

  // simple dual-port, dual-clock array: no reset so block RAM can be inferred
  always_ff @(posedge wclk) begin
    store[waddr] <= wbit;
  end

  always_ff @(posedge rclk) begin
    if (rrst) rbit <= 1'b0;
    else      rbit <= store[raddr];
  end
endmodule

// File: rtl/sbm_wr.sv
module sbm_wr
  import sbm_pkg::*;
#(
  parameter int AW = 9,
  parameter int FW = 8
) (
  input  logic          wclk,
  input  logic          wrst,
  input  logic          line_fp,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] wgray
);
  logic [AW-1:0] wptr;
  logic [AW-1:0] wnext;

  // a frame marker rounds the write address up to the next frame start
  always_comb begin
    waddr = wptr;
    if (line_fp) waddr = {wptr[AW-1] ^ (|wptr[FW-1:0]), {FW{1'b0}}};
    wnext = waddr + 1'b1;
  end

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wptr  <= '0;
      wgray <= '0;
    end else begin
      wptr  <= wnext;
      wgray <= AW'(to_gray(16'(wnext)));
    end
  end

  // R10: the crossing pointer moves by exactly one Gray bit per plain write
  p_gray_step_r10: assert property (@(posedge wclk) disable iff (wrst)
    !line_fp |=> $countones(wgray ^ $past(wgray)) == 1);
endmodule

// File: rtl/sbm_rd.sv
module sbm_rd
  import sbm_pkg::*;
#(
  parameter int AW    = 9,
  parameter int FW    = 8,
  parameter int GUARD = 16,
  parameter int SYNC  = 2
) (
  input  logic          rclk,
  input  logic          rrst,
  input  logic          sys_fp,
  input  logic [AW-1:0] wgray,
  output logic [AW-1:0] raddr,
  output logic          slip_toggle,
  output logic          slip_repeat,
  output logic [AW-1:0] phase_word
);
  localparam logic [AW-1:0] LOW_LIM  = AW'(GUARD);
  localparam logic [AW-1:0] HIGH_LIM = AW'(2 ** AW - GUARD);
  localparam logic [AW-1:0] FLIP     = {1'b1, {FW{1'b0}}};

  logic [AW-1:0] sync_q [SYNC];
  logic [AW-1:0] wseen, rptr, base, start, gap, gap2;
  logic          pair_q;
  slip_e         kind;

  always_ff @(posedge rclk) begin
    if (rrst) begin
      for (int i = 0; i < SYNC; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= wgray;
      for (int i = 1; i < SYNC; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign wseen = AW'(from_gray(16'(sync_q[SYNC-1])));

  always_comb begin
    base = {rptr[AW-1] ^ (|rptr[FW-1:0]), {FW{1'b0}}};
    gap  = wseen - base;
    if (gap < LOW_LIM)       kind = SLIP_REPEAT;
    else if (gap > HIGH_LIM) kind = SLIP_DROP;
    else                     kind = SLIP_NONE;
    start = (kind == SLIP_NONE) ? base : (base ^ FLIP);
    gap2  = wseen - start;
    raddr = sys_fp ? start : rptr;
  end

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rptr        <= '0;
      slip_toggle <= 1'b0;
      slip_repeat <= 1'b0;
      phase_word  <= '0;
      pair_q      <= 1'b0;
    end else begin
      rptr <= raddr + 1'b1;
      if (sys_fp) begin
        if (kind != SLIP_NONE) begin
          slip_toggle <= ~slip_toggle;
          slip_repeat <= (kind == SLIP_REPEAT);
        end
        if (!pair_q) phase_word <= {~gap2[AW-1], gap2[FW-1:0]};
        pair_q <= ~pair_q;
      end
    end
  end

  // R5: slips happen only at a read frame boundary
  p_slip_on_boundary_r5: assert property (@(posedge rclk) disable iff (rrst)
    !sys_fp |=> $stable(slip_toggle));
  // R6: the direction flag holds between frame pulses
  p_dir_hold_r6: assert property (@(posedge rclk) disable iff (rrst)
    !sys_fp |=> $stable(slip_repeat));
  // R9: the phase word is only refreshed at frame pulses
  p_phase_hold_r9: assert property (@(posedge rclk) disable iff (rrst)
    !sys_fp |=> $stable(phase_word));
  // R3: one frame jump always restores a separation inside the guards
  p_gap_window_r3: assert property (@(posedge rclk) disable iff (rrst)
    sys_fp |-> (gap2 >= LOW_LIM && gap2 <= HIGH_LIM));
endmodule

// File: rtl/slip_buffer_monitor.sv
module slip_buffer_monitor #(
  parameter int SLOTS       = 32,
  parameter int SLOT_BITS   = 8,
  parameter int GUARD_SLOTS = 2,
  parameter int SYNC_STAGES = 2,
  localparam int FW         = $clog2(SLOTS * SLOT_BITS),
  localparam int AW         = FW + 1
) (
  input  logic          wclk,
  input  logic          wrst,
  input  logic          line_fp,
  input  logic          line_bit,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          sys_fp,
  output logic          sys_bit,
  output logic          slip_toggle,
  output logic          slip_repeat,
  output logic [AW-1:0] phase_word
);
  localparam int GUARD = GUARD_SLOTS * SLOT_BITS;

  logic [AW-1:0] waddr, wgray, raddr;

  sbm_wr #(.AW(AW), .FW(FW)) u_wr (
    .wclk    (wclk),
    .wrst    (wrst),
    .line_fp (line_fp),
    .waddr   (waddr),
    .wgray   (wgray)
  );

  sbm_rd #(.AW(AW), .FW(FW), .GUARD(GUARD), .SYNC(SYNC_STAGES)) u_rd (
    .rclk        (rclk),
    .rrst        (rrst),
    .sys_fp      (sys_fp),
    .wgray       (wgray),
    .raddr       (raddr),
    .slip_toggle (slip_toggle),
    .slip_repeat (slip_repeat),
    .phase_word  (phase_word)
  );

  sbm_mem #(.AW(AW)) u_mem (
    .wclk  (wclk),
    .waddr (waddr),
    .wbit  (line_bit),
    .rclk  (rclk),
    .rrst  (rrst),
    .raddr (raddr),
    .rbit  (sys_bit)
  );
endmodule

// File: tb/slip_buffer_monitor_bench.sv
`timescale 1ps/1ps
module slip_buffer_monitor_bench;
  logic wclk = 1'b0, rclk = 1'b0;
  logic wrst = 1'b1, rrst = 1'b1;
  logic line_fp = 1'b0, line_bit = 1'b0, sys_fp = 1'b0;
  logic sys_bit, slip_toggle, slip_repeat;
  logic [8:0] phase_word;

  int checks = 0, errors = 0;
  int whigh = 1900;             // line clock high time; low time fixed at 2000 ps
  int rcyc = 0, wcyc = 0, rbits = 0, wsent = 0;
  bit phase_b = 0, done = 0;

  slip_buffer_monitor u_slip_buffer_monitor (
    .wclk(wclk), .wrst(wrst), .line_fp(line_fp), .line_bit(line_bit),
    .rclk(rclk), .rrst(rrst), .sys_fp(sys_fp), .sys_bit(sys_bit),
    .slip_toggle(slip_toggle), .slip_repeat(slip_repeat), .phase_word(phase_word));

  // 250 MHz system clock; line clock edges always sit 50 ps off the 100 ps grid
  always #2000 rclk = ~rclk;
  initial begin
    #1050;
    forever begin
      wclk = 1'b1; #(whigh);
      wclk = 1'b0; #2000;
    end
  end

  // stimulus, line side
  always @(negedge wclk) begin
    wcyc++;
    if (wcyc < 6) wrst = 1'b1;
    else begin
      wrst     = 1'b0;
      line_fp  = (wsent % 256 == 0);
      line_bit = 1'($urandom);
      wsent++;
    end
  end

  // stimulus, system side
  always @(negedge rclk) begin
    rcyc++;
    if (rcyc < 6) rrst = 1'b1;
    else begin
      rrst   = 1'b0;
      sys_fp = (rbits % 256 == 0);
      rbits++;
    end
  end

  // reference model on absolute bit indices
  bit wbits [int];
  int wabs = 0, rabs = 0, h1 = 0, h2 = 0;
  bit m_tgl = 0, m_dir = 0, m_par = 0, m_valid = 1, m_bit = 0;
  logic [8:0] m_ph = '0;

  always @(posedge wclk) begin
    if (wrst) wabs = 0;
    else begin
      wbits[wabs] = line_bit;
      wabs++;
    end
  end

  always @(posedge rclk) begin
    if (rrst) begin
      rabs = 0; h1 = 0; h2 = 0; m_tgl = 0; m_dir = 0; m_par = 0;
      m_ph = '0; m_valid = 1; m_bit = 0;
    end else begin
      int seen, addr, d;
      seen = h2; h2 = h1; h1 = wabs;      // R10: two-edge view of the write count
      addr = rabs;
      if (sys_fp) begin
        d = seen - addr;
        if (d < 16) begin addr -= 256; m_tgl = !m_tgl; m_dir = 1; end       // R3
        else if (d > 496) begin addr += 256; m_tgl = !m_tgl; m_dir = 0; end  // R4
        d = seen - addr;
        if (!m_par) m_ph = {(d < 256) ? 1'b1 : 1'b0, 8'(d % 256)};           // R7 R8 R9
        m_par = !m_par;
      end
      m_valid = wbits.exists(addr);
      m_bit   = m_valid ? wbits[addr] : 1'b0;
      rabs    = addr + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  int drops_a = 0, repeats_b = 0;
  logic prev_tgl = 1'b0;

  always @(negedge rclk) begin
    if (!done) begin
      if (rrst) begin
        check("R1 sys_bit", sys_bit, 0);
        check("R1 slip_toggle", slip_toggle, 0);
        check("R1 slip_repeat", slip_repeat, 0);
        check("R1 phase_word", phase_word, 0);
      end else begin
        if (m_valid) check("R2 sys_bit", sys_bit, m_bit);
        check("R5 slip_toggle", slip_toggle, m_tgl);
        check("R6 slip_repeat", slip_repeat, m_dir);
        check("R7 R8 R9 R10 phase_word", phase_word, m_ph);
        if (slip_toggle != prev_tgl) begin
          if (!phase_b && !slip_repeat) drops_a++;
          if (phase_b && slip_repeat) repeats_b++;
        end
      end
      prev_tgl = slip_toggle;
    end
  end

  initial begin
    fork
      begin
        wait (rcyc == 40000);
        check("R4 drop slips seen with fast line clock", drops_a > 0, 1);
        whigh = 2100; phase_b = 1;
        wait (rcyc == 80000);
        check("R3 repeat slips seen with slow line clock", repeats_b > 0, 1);
      end
      begin
        wait (rcyc == 150000);
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", rcyc);
      end
    join_any
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule